// File: doc/BRIEF.md
# Built-In Logic Block Observer Register

A register of parameterised width that serves as an ordinary pipeline register, a pseudo-random pattern generator (PRPG), a multiple-input signature register (MISR) or a scan chain. Two mode bits select the function. The same flip-flops are used in all four modes. The first stage is fed through a multiplexer that picks either the external serial input or the internal LFSR feedback. The most significant stage drives the serial output.

In pattern and signature modes the register steps as a modular (Galois) LFSR. The characteristic polynomial is a parameter, and the default x^4+x+1 is maximal-length at width 4. In signature mode the parallel inputs are XORed into every stage in the same cycle as the feedback. The register therefore compacts a parallel response stream into one remainder. Scan mode shifts the register by one stage per clock without feedback, so a seed can be loaded and a signature can be unloaded serially.

Top module: `bilbo_reg`

## Requirements
- R1: While `rst_ni` is low, all stages are zero, so `par_o` is 0 and `scan_o` is 0.
- R2: The mode is `mode_i` = {c1,c2}. When it is 2'b11, `par_o` takes the value of `par_i` at the next rising clock edge.
- R3: When `mode_i` is 2'b00 (scan), the register shifts toward the MSB on each clock. Stage 0 takes `scan_i`, and stage i takes stage i-1 with no feedback XOR.
- R4: `scan_o` always equals the most significant stage, `par_o[WIDTH-1]`.
- R5: When `mode_i` is 2'b01 (PRPG), the register makes one modular LFSR step: next = {q[W-2:0],0} XOR ({POLY[W-1:1],1} if q[W-1] is 1). The default POLY is 4'b0011, which gives x^4+x+1. `par_i` has no effect on this step.
- R6: In PRPG mode, a non-zero state never steps to zero. Starting from any non-zero seed, the default polynomial visits 2^WIDTH-1 distinct states and returns to the seed exactly after that many steps.
- R7: When `mode_i` is 2'b10 (MISR), next = the R5 step XOR `par_i`.
- R8: `scan_i` has no effect in any mode other than scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Mode select {c1,c2} |
| par_i | input | WIDTH | Parallel data / response input |
| scan_i | input | 1 | Serial scan input to stage 0 |
| par_o | output | WIDTH | Register contents |
| scan_o | output | 1 | Serial output from the last stage |

## Verification
In signature mode, two effects can land on the same stage in the same cycle: the feedback from the MSB and the injected parallel response bit. The bench provokes this with random `par_i` while the register is in MISR mode, so that it often holds a 1 in its MSB. Each cycle it compares the register with a model that applies both XORs. The bench also drives random `scan_i` in every mode. A wrong first-stage multiplexer choice would then mix serial data into the feedback path, and the same per-cycle comparison catches it.

// File: rtl/bilbo_pkg.sv
package bilbo_pkg;
  typedef enum logic [1:0] {
    MODE_SCAN = 2'b00,
    MODE_PRPG = 2'b01,
    MODE_MISR = 2'b10,
    MODE_LOAD = 2'b11
  } bilbo_mode_e;
endpackage

// File: rtl/bilbo_fb.sv
module bilbo_fb
  import bilbo_pkg::*;
(
  input  bilbo_mode_e mode_i,
  input  logic        msb_i,
  input  logic        scan_i,
  output logic        fb_o,
  output logic        head_o
);
  // feedback only in the two LFSR modes
  assign fb_o   = ((mode_i == MODE_PRPG) || (mode_i == MODE_MISR)) ? msb_i : 1'b0;
  // first-stage mux: serial input vs feedback
  assign head_o = (mode_i == MODE_SCAN) ? scan_i : fb_o;
endmodule

// File: rtl/bilbo_cell.sv
module bilbo_cell
  import bilbo_pkg::*;
#(
  parameter bit TAP = 1'b0
) (
  input  bilbo_mode_e mode_i,
  input  logic        prev_i,
  input  logic        fb_i,
  input  logic        par_i,
  output logic        d_o
);
  always_comb begin
    unique case (mode_i)
      MODE_LOAD: d_o = par_i;
      MODE_SCAN: d_o = prev_i;
      MODE_PRPG: d_o = prev_i ^ (TAP & fb_i);
      MODE_MISR: d_o = prev_i ^ (TAP & fb_i) ^ par_i;
      default:   d_o = prev_i;
    endcase
  end
endmodule

// File: rtl/bilbo_reg.sv
module bilbo_reg
  import bilbo_pkg::*;
#(
  parameter int unsigned      WIDTH = 4,
  parameter logic [WIDTH-1:0] POLY  = 4'b0011
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic [WIDTH-1:0] par_i,
  input  logic             scan_i,
  output logic [WIDTH-1:0] par_o,
  output logic             scan_o
);
  localparam int unsigned MSB = WIDTH - 1;

  bilbo_mode_e      mode;
  logic [WIDTH-1:0] q_q, d;
  logic             fb, head;

  assign mode = bilbo_mode_e'(mode_i);

  bilbo_fb u_fb (
    .mode_i (mode),
    .msb_i  (q_q[MSB]),
    .scan_i (scan_i),
    .fb_o   (fb),
    .head_o (head)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    logic prev;
    if (i == 0) begin : g_head
      assign prev = head;
    end else begin : g_body
      assign prev = q_q[i-1];
    end
    // stage 0 already carries fb through the head mux
    bilbo_cell #(.TAP((i == 0) ? 1'b0 : POLY[i])) u_cell (
      .mode_i (mode),
      .prev_i (prev),
      .fb_i   (fb),
      .par_i  (par_i[i]),
      .d_o    (d[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= d;
  end

  assign par_o  = q_q;
  assign scan_o = q_q[MSB];

  // R2
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b11) |=> (par_o == $past(par_i)));

  // R3
  scan_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b00) |=> (par_o == {$past(par_o[MSB-1:0]), $past(scan_i)}));

  // R3
  scan_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b00) |=> (scan_o == $past(par_o[MSB-1])));

  // R6
  no_lockup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_i == 2'b01) && (par_o != '0)) |=> (par_o != '0));

  // R5
  prpg_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_i == 2'b01) && (par_o == '0)) |=> (par_o == '0));

  // R1
  reset_chk: assert property (@(posedge clk_i) !rst_ni |-> (par_o == '0));
endmodule

// File: tb/bilbo_reg_bench.sv
module bilbo_reg_bench;
  localparam int W = 4;
  localparam logic [W-1:0] POLY = 4'b0011;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   mode = 2'b11;
  logic [W-1:0] par = '0;
  logic         sin = 1'b0;
  logic [W-1:0] par_o;
  logic         scan_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [W-1:0] model;

  always #10 clk = ~clk;

  bilbo_reg #(.WIDTH(W), .POLY(POLY)) u_bilbo_reg (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .par_i(par),
    .scan_i(sin), .par_o(par_o), .scan_o(scan_o)
  );

  function automatic logic [W-1:0] step(logic [W-1:0] q, logic [1:0] m,
                                        logic [W-1:0] p, logic s);
    logic [W-1:0] lfsr;
    lfsr = {q[W-2:0], 1'b0} ^ (q[W-1] ? (POLY | 1) : '0);
    case (m)
      2'b11:   return p;
      2'b00:   return {q[W-2:0], s};
      2'b01:   return lfsr;
      default: return lfsr ^ p;
    endcase
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive away from the edge, sample one step after it
  task automatic cyc(logic [1:0] m, logic [W-1:0] p, logic s, string req);
    @(negedge clk);
    mode = m; par = p; sin = s;
    model = step(model, m, p, s);
    @(posedge clk); #1;
    check(req, par_o, model);
    check("R4", {{(W-1){1'b0}}, scan_o}, {{(W-1){1'b0}}, model[W-1]});
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'd1234);
    model = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", par_o, '0);
    check("R1", {{(W-1){1'b0}}, scan_o}, '0);
    @(negedge clk); rst_n = 1'b1;

    // R2 directed load
    cyc(2'b11, 4'hA, 1'b1, "R2");
    cyc(2'b11, 4'hF, 1'b0, "R2");
    // R3 scan a pattern in
    cyc(2'b00, 4'h0, 1'b1, "R3");
    cyc(2'b00, 4'h0, 1'b0, "R3");
    cyc(2'b00, 4'h0, 1'b1, "R3");
    // R5 with par_i noise, R8 with scan_i noise
    cyc(2'b11, 4'h8, 1'b0, "R2");
    cyc(2'b01, 4'hF, 1'b1, "R5/R8");
    cyc(2'b01, 4'h5, 1'b1, "R5/R8");
    // R7 feedback and injection in the same stage
    cyc(2'b11, 4'h8, 1'b0, "R2");
    cyc(2'b10, 4'h3, 1'b1, "R7");

    // R6 full period from seed 1
    begin
      logic [W-1:0] seen;
      logic [(1<<W)-1:0] visited;
      cyc(2'b11, 4'h1, 1'b0, "R2");
      visited = '0;
      visited[1] = 1'b1;
      for (int k = 1; k < (1 << W); k++) begin
        cyc(2'b01, W'($urandom), 1'($urandom), "R6");
        seen = par_o;
        checks++;
        if (seen == '0 || (k < (1 << W) - 1 && visited[seen])) begin
          fails++;
          $display("FAIL R6 actual=%h expected=new non-zero state at step %0d", seen, k);
        end
        visited[seen] = 1'b1;
      end
      check("R6", par_o, 4'h1);
    end

    // random mix of all modes
    for (int n = 0; n < 400; n++) begin
      cyc(2'($urandom), W'($urandom), 1'($urandom), "R2/R3/R5/R7/R8");
    end

    // R1 asynchronous reset mid-run
    @(negedge clk); mode = 2'b11; par = 4'hF;
    @(posedge clk); #5 rst_n = 1'b0; #1;
    check("R1", par_o, '0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule